// File: doc/BRIEF.md
# Fast A20 Gate and Software CPU Reset Port

This block is an 8-bit legacy system control port that sits at I/O address 92h. Software uses it for two things. It can drive the address-line-20 gate without going through the keyboard controller. It can also ask for a CPU reset pulse that fires on its own after a short delay. The host side is a simple strobe bus: an address, a write strobe, a read strobe, and write and read data. A configuration input enables the port. The keyboard controller's own A20 gate and active-low reset are merged into the block's two outputs.

A data write that moves the reset-request bit from 0 to 1 starts a one-shot sequence. The internal reset line stays inactive for a minimum delay of 14 µs, then goes active for a minimum of 6 µs. Both intervals are counted in clock cycles, and the counts are worked out from a clock-frequency parameter. Software must clear the bit before it can request another pulse. A polarity input picks whether the combined reset output is active low or active high.

Top module: `fast_a20_reset_port`

## Requirements
- R1: After system reset the port reads 24h, the alternate A20 line is low, and the combined reset output is at its inactive level.
- R2: Read bits 7:6 are always 00, bit 5 is 1, bits 4 and 3 are 0, and bit 2 is 1. Write data on bits 7:2 is ignored.
- R3: A write with data bit 1 set raises the alternate A20 line, and a write with bit 1 clear lowers it. Bit 1 reads back as last written.
- R4: `a20_out` is high when `kbc_a20` is high or when the alternate A20 line is high while the port is enabled. It is low only when both are low.
- R5: A write that moves bit 0 from 0 to 1 keeps the reset inactive through DLY = ceil(14000 ns × f) cycles and asserts it on the (DLY+1)th clock edge after the write edge. The reset then stays active for exactly WID = ceil(6000 ns × f) cycles. Here f is the clock frequency.
- R6: Only one pulse is produced per setting of bit 0. Writing 1 again while bit 0 is already 1 produces no pulse. A write of 0 followed by a write of 1 produces a new pulse. Bit 0 reads back as last written.
- R7: A clear-and-set of bit 0 during a running delay or pulse neither restarts nor extends that sequence. Clearing bit 0 mid-sequence lets the sequence finish.
- R8: System reset clears bit 0, aborts any running sequence, and holds the alternate reset inactive.
- R9: With `port_en` low, writes to the port are ignored, reads return 00h, and the alternate A20 and reset sources are masked. Reads at any other address return 00h.
- R10: The combined reset is active when `kbc_rst_n` is low or the alternate pulse is active. With `out_pol` = 0, `cpu_rst_out` is low when active. With `out_pol` = 1, it is high when active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_addr | input | ADDR_W | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 00h unless the port is hit and enabled |
| port_en | input | 1 | Port enable from the reset/A20 configuration |
| out_pol | input | 1 | Reset output polarity: 0 active low, 1 active high |
| kbc_a20 | input | 1 | Keyboard controller A20 gate, active high |
| kbc_rst_n | input | 1 | Keyboard controller CPU reset, active low |
| a20_out | output | 1 | Combined A20 gate |
| cpu_rst_out | output | 1 | Combined CPU reset, polarity per `out_pol` |

## Verification
The bench measures the pulse edge-to-edge in clock cycles. A design with an off-by-one counter, or one that rounds the intervals down, shows up as a wrong delay or width count.

It repeats a write of 1 while bit 0 is already set. A design that triggers on the level instead of the rising transition would fire again here. It also clears and sets the bit mid-delay. A design that restarts the timer would shift the pulse start.

Further checks cover a system reset in the middle of a pulse and writes to a disabled port. A wrongly gated design would leave the reset stuck active in the first case and latch data or emit a pulse in the second.

// File: rtl/a20rst_pkg.sv
package a20rst_pkg;

   typedef enum logic [1:0] {
      TMR_IDLE  = 2'd0,
      TMR_DELAY = 2'd1,
      TMR_PULSE = 2'd2
   } tmr_state_e;

   // Fixed value of the reserved read bits 7:2
   localparam logic [5:0] RSVD_BITS = 6'b001001;

   // Number of clock cycles covering at least ns_min nanoseconds
   function automatic int unsigned ns_to_cycles(input longint ns_min, input longint clk_khz);
      longint prod;
      prod = ns_min * clk_khz;
      return int'((prod + 64'd999_999) / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/a20rst_regfile.sv
module a20rst_regfile #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] PORT_ADDR = 16'h0092
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   input  logic              port_en,
   output logic [7:0]        bus_rdata,
   output logic              alt_a20,
   output logic              rst_req,
   output logic              arm
);
   import a20rst_pkg::*;

   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);

   logic hit, wr_hit;
   logic unused_wbits;

   assign hit          = (bus_addr == MY_ADDR) && port_en;
   assign wr_hit       = bus_wr && hit;
   assign unused_wbits = ^bus_wdata[7:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alt_a20 <= 1'b0;
         rst_req <= 1'b0;
         arm     <= 1'b0;
      end else begin
         arm <= wr_hit && bus_wdata[0] && !rst_req;
         if (wr_hit) begin
            alt_a20 <= bus_wdata[1];
            rst_req <= bus_wdata[0];
         end
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd && hit)
         bus_rdata = {RSVD_BITS, alt_a20, rst_req};
   end

   AST_ALT_A20_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (alt_a20 == $past(bus_wdata[1])));  // R3
   AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !port_en) |=> ($stable(alt_a20) && $stable(rst_req) && !arm));  // R9
   AST_ARM_ONLY_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> (rst_req && !$past(rst_req)));  // R6

endmodule

// File: rtl/a20rst_timer.sv
module a20rst_timer #(
   parameter int unsigned DLY_CYC = 462,
   parameter int unsigned WID_CYC = 198
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic alt_rst_n
);
   import a20rst_pkg::*;

   localparam int unsigned MAX_CYC = (DLY_CYC > WID_CYC) ? DLY_CYC : WID_CYC;
   localparam int          CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'(DLY_CYC - 1);
   localparam logic [CNT_W-1:0] WID_LOAD = CNT_W'(WID_CYC - 1);

   tmr_state_e       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            TMR_IDLE: begin
               if (arm) begin
                  state <= TMR_DELAY;
                  cnt   <= DLY_LOAD;
               end
            end
            TMR_DELAY: begin
               if (cnt == '0) begin
                  state <= TMR_PULSE;
                  cnt   <= WID_LOAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            TMR_PULSE: begin
               if (cnt == '0) state <= TMR_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: begin
               state <= TMR_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign alt_rst_n = (state != TMR_PULSE);

   AST_ARM_STARTS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TMR_IDLE && arm) |=> (state == TMR_DELAY));  // R5
   AST_PULSE_FROM_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alt_rst_n) |-> ($past(state) == TMR_DELAY));  // R5
   AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TMR_PULSE && cnt != '0) |=> (state == TMR_PULSE));  // R7
   AST_DELAY_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TMR_DELAY && cnt != '0) |=> (state == TMR_DELAY && cnt == $past(cnt) - 1'b1));  // R7

endmodule

// File: rtl/a20rst_outmux.sv
module a20rst_outmux #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic port_en,
   input  logic out_pol,
   input  logic kbc_a20,
   input  logic alt_a20,
   input  logic kbc_rst_n,
   input  logic alt_rst_n,
   output logic a20_out,
   output logic cpu_rst_out
);
   logic a20_c, rst_act_n, rst_c;

   assign a20_c     = kbc_a20 | (port_en & alt_a20);
   assign rst_act_n = kbc_rst_n & (alt_rst_n | ~port_en);
   assign rst_c     = out_pol ? ~rst_act_n : rst_act_n;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a20_out     <= 1'b0;
               cpu_rst_out <= ~out_pol;
            end else begin
               a20_out     <= a20_c;
               cpu_rst_out <= rst_c;
            end
         end
      end else begin : g_comb
         assign a20_out     = a20_c;
         assign cpu_rst_out = rst_c;

         AST_KBC_RESET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
            !kbc_rst_n |-> (cpu_rst_out == out_pol));  // R10
         AST_A20_KBC_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
            kbc_a20 |-> a20_out);  // R4
      end
   endgenerate

endmodule

// File: rtl/fast_a20_reset_port.sv
module fast_a20_reset_port #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] PORT_ADDR = 16'h0092,
   parameter int          CLK_KHZ   = 33000,
   parameter int          DELAY_NS  = 14000,
   parameter int          WIDTH_NS  = 6000,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              port_en,
   input  logic              out_pol,
   input  logic              kbc_a20,
   input  logic              kbc_rst_n,
   output logic              a20_out,
   output logic              cpu_rst_out
);
   import a20rst_pkg::*;

   localparam int unsigned DLY_CYC = ns_to_cycles(longint'(DELAY_NS), longint'(CLK_KHZ));
   localparam int unsigned WID_CYC = ns_to_cycles(longint'(WIDTH_NS), longint'(CLK_KHZ));

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W must lie in 8..16");
      end
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("CLK_KHZ must be positive");
      end
      if (DLY_CYC < 1 || WID_CYC < 1) begin : g_bad_times
         $error("delay and width must each cover at least one cycle");
      end
   endgenerate

   logic alt_a20, rst_req, arm, alt_rst_n;

   a20rst_regfile #(
      .ADDR_W    (ADDR_W),
      .PORT_ADDR (PORT_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .port_en   (port_en),
      .bus_rdata (bus_rdata),
      .alt_a20   (alt_a20),
      .rst_req   (rst_req),
      .arm       (arm)
   );

   a20rst_timer #(
      .DLY_CYC (DLY_CYC),
      .WID_CYC (WID_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .alt_rst_n (alt_rst_n)
   );

   a20rst_outmux #(
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .port_en     (port_en),
      .out_pol     (out_pol),
      .kbc_a20     (kbc_a20),
      .alt_a20     (alt_a20),
      .kbc_rst_n   (kbc_rst_n),
      .alt_rst_n   (alt_rst_n),
      .a20_out     (a20_out),
      .cpu_rst_out (cpu_rst_out)
   );

   AST_REQ_CLEARED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rst_req);  // R8
   AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en) |-> (bus_rdata == 8'h00));  // R9

endmodule

// File: tb/fast_a20_reset_port_tb.sv
module fast_a20_reset_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_KHZ    = 33000;
   localparam int DLY = (14000 * CLK_KHZ + 999_999) / 1_000_000;
   localparam int WID = (6000 * CLK_KHZ + 999_999) / 1_000_000;
   localparam int SEQ = DLY + WID + 20;
   localparam int WATCHDOG = 50000;

   // {port_en, kbc_a20, write bit1, expected a20_out}
   localparam logic [3:0] VEC [8] = '{
      4'b0_0_0_0, 4'b0_0_1_0, 4'b0_1_0_1, 4'b0_1_1_1,
      4'b1_0_0_0, 4'b1_0_1_1, 4'b1_1_0_1, 4'b1_1_1_1
   };

   logic clk = 0, rst_n = 0;
   logic [15:0] bus_addr = 16'h0092;
   logic bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic port_en = 1, out_pol = 0, kbc_a20 = 0, kbc_rst_n = 1;
   logic a20_out, cpu_rst_out;

   int tests = 0, fails = 0;
   bit done = 0;
   int cyc = 0;
   int mon_pulses = 0, mon_act = 0, mon_rise = 0;
   logic prev_act = 0;

   fast_a20_reset_port #(.CLK_KHZ(CLK_KHZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_en(port_en), .out_pol(out_pol),
      .kbc_a20(kbc_a20), .kbc_rst_n(kbc_rst_n), .a20_out(a20_out), .cpu_rst_out(cpu_rst_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      logic act;
      act = out_pol ? cpu_rst_out : ~cpu_rst_out;
      if (act && !prev_act) begin
         mon_pulses <= mon_pulses + 1;
         mon_rise   <= cyc;
      end
      if (act) mon_act <= mon_act + 1;
      prev_act <= act;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); bus_wdata = d; bus_wr = 1;
      @(posedge clk);
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk); bus_rd = 1;
      #1 d = bus_rdata;
      bus_rd = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      finish_run();
   end

   initial begin
      logic [7:0] d;
      int bp, ba, t0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      rd(d); check(d == 8'h24, "R1 reset read", d, 8'h24);
      check(a20_out == 0, "R1 a20 low", a20_out, 0);
      check(cpu_rst_out == 1, "R1 reset inactive", cpu_rst_out, 1);

      // R3 R4 R9 table walk
      foreach (VEC[i]) begin
         port_en = 1; kbc_a20 = 0;
         wr({6'b0, VEC[i][1], 1'b0});
         port_en = VEC[i][3]; kbc_a20 = VEC[i][2];
         #1 check(a20_out == VEC[i][0], "R4 a20 combine", a20_out, VEC[i][0]);
         rd(d);
         check(d == (VEC[i][3] ? (8'h24 | {6'b0, VEC[i][1], 1'b0}) : 8'h00), "R3 readback", d,
               VEC[i][3] ? (8'h24 | {6'b0, VEC[i][1], 1'b0}) : 8'h00);
      end
      port_en = 1; kbc_a20 = 0;

      // R2 reserved bits ignored
      wr(8'hFC); rd(d); check(d == 8'h24, "R2 reserved ignored", d, 8'h24);
      wr(8'hDA); rd(d); check(d == 8'h26, "R2 reserved with bit1", d, 8'h26);
      wr(8'h00);

      // R5 delay and width
      bp = mon_pulses; ba = mon_act;
      wr(8'h01); t0 = cyc;
      repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 1, "R5 one pulse", mon_pulses - bp, 1);
      check(mon_rise - t0 == DLY + 1, "R5 delay", mon_rise - t0, DLY + 1);
      check(mon_act - ba == WID, "R5 width", mon_act - ba, WID);

      // R6 rewrite 1 without clearing
      bp = mon_pulses;
      wr(8'h01); repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 0, "R6 no retrigger", mon_pulses - bp, 0);
      rd(d); check(d == 8'h25, "R6 bit0 readback", d, 8'h25);
      bp = mon_pulses;
      wr(8'h00); wr(8'h01); repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 1, "R6 clear then set", mon_pulses - bp, 1);

      // R7 clear and set during the delay
      wr(8'h00);
      bp = mon_pulses; ba = mon_act;
      wr(8'h01); t0 = cyc;
      repeat (50) @(negedge clk);
      wr(8'h00); wr(8'h01);
      repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 1, "R7 single pulse", mon_pulses - bp, 1);
      check(mon_rise - t0 == DLY + 1, "R7 not restarted", mon_rise - t0, DLY + 1);
      check(mon_act - ba == WID, "R7 not extended", mon_act - ba, WID);
      wr(8'h00); bp = mon_pulses;
      wr(8'h01); repeat (20) @(negedge clk);
      wr(8'h00); repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 1, "R7 clear lets finish", mon_pulses - bp, 1);

      // R8 system reset mid-pulse
      wr(8'h01); repeat (DLY + 10) @(negedge clk);
      check(cpu_rst_out == 0, "R8 pulse active before reset", cpu_rst_out, 0);
      rst_n = 0; #1;
      check(cpu_rst_out == 1, "R8 reset forces inactive", cpu_rst_out, 1);
      repeat (2) @(negedge clk); rst_n = 1;
      rd(d); check(d == 8'h24, "R8 bit0 cleared", d, 8'h24);
      bp = mon_pulses; repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 0, "R8 no pulse after reset", mon_pulses - bp, 0);

      // R9 disabled port
      port_en = 0; bp = mon_pulses;
      wr(8'h03); repeat (SEQ) @(negedge clk);
      check(mon_pulses - bp == 0, "R9 disabled no pulse", mon_pulses - bp, 0);
      check(a20_out == 0, "R9 disabled a20", a20_out, 0);
      rd(d); check(d == 8'h00, "R9 disabled read", d, 8'h00);
      port_en = 1; rd(d); check(d == 8'h24, "R9 write ignored", d, 8'h24);
      bus_addr = 16'h0093; rd(d); check(d == 8'h00, "R9 other address", d, 8'h00);
      bus_addr = 16'h0092;

      // R10 keyboard reset and polarity
      kbc_rst_n = 0; #1 check(cpu_rst_out == 0, "R10 kbc reset low pol", cpu_rst_out, 0);
      out_pol = 1; #1 check(cpu_rst_out == 1, "R10 kbc reset high pol", cpu_rst_out, 1);
      kbc_rst_n = 1; #1 check(cpu_rst_out == 0, "R10 inactive high pol", cpu_rst_out, 0);
      out_pol = 0; #1 check(cpu_rst_out == 1, "R10 inactive low pol", cpu_rst_out, 1);

      finish_run();
   end
endmodule